// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between an on-chip host running on the system clock and an external asynchronous 8K x 8 static RAM. The host presents one request at a time through a valid/ready handshake: a 13-bit address, a read/write flag and 8-bit write data. The controller turns each accepted request into a strobe sequence on the RAM pins. For a read it returns one byte with a one-cycle valid flag.

The RAM is selected only while its active-low and active-high selects are both asserted. A write is performed only while the write strobe is low inside that selection window. All RAM timing is given as module parameters in whole clock cycles; each is rounded up from nanoseconds and clamped to at least one cycle.

By default the output enable is held inactive for the whole of a write, so the write pulse is limited only by its own minimum width. With `KEEP_OE_IN_WRITE` set, the output enable stays active through a write. In that case the pulse is stretched, and the data driver waits for the RAM's outputs to float before it turns on.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held, and in every cycle in which `req_ready` is high, the RAM pins rest at `ram_ce_n`=1, `ram_ce_hi`=0, `ram_oe_n`=1, `ram_we_n`=1 and `ram_wdrive`=0.
- R2: `ram_ce_n` is low in exactly the cycles in which `ram_ce_hi` is high, so the device is never half selected.
- R3: A write drives `ram_we_n` low only while both selects are active, starting in the first cycle after acceptance. It stays low for exactly WP = max(T_WR_PULSE, S + T_DATA_SETUP) cycles, where S = T_WR_HIZ if `KEEP_OE_IN_WRITE`=1 and S = 0 otherwise.
- R4: With `KEEP_OE_IN_WRITE`=0, `ram_oe_n` is high in every cycle of a write.
- R5: With `KEEP_OE_IN_WRITE`=1, `ram_oe_n` stays low through the write pulse. `ram_wdrive` stays low during the first T_WR_HIZ cycles of the pulse, so the RAM and the controller never drive the bus together.
- R6: `ram_wdrive` is high only while `ram_we_n` is low with the device selected. Within a pulse it is high continuously from pulse cycle S+1 to the end of the pulse, which gives WP-S cycles, at least T_DATA_SETUP. While it is high, `ram_wdata` carries the accepted write data.
- R7: A read holds both selects and `ram_oe_n` active for RD = max(T_RD_CYCLE, T_RD_ACCESS) cycles. `rd_data` takes the value of `ram_rdata` at the clock edge that closes the T_RD_ACCESS-th cycle of the access. `rd_valid` is high for exactly the one cycle after that edge, and is never high because of a write.
- R8: After an accepted request, `req_ready` is low for exactly RD cycles (read) or max(T_WR_CYCLE, WP) cycles (write). A request presented while `req_ready` is low is not accepted and causes no RAM access.
- R9: `ram_addr` does not change while the device is selected. A read returns the data most recently written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host presents a request |
| req_ready | output | 1 | Controller idle; a request is taken on this edge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Captured read data |
| rd_valid | output | 1 | One-cycle flag for `rd_data` |
| ram_addr | output | 13 | RAM address pins |
| ram_ce_n | output | 1 | Active-low RAM select |
| ram_ce_hi | output | 1 | Active-high RAM select |
| ram_oe_n | output | 1 | Active-low RAM output enable |
| ram_we_n | output | 1 | Active-low RAM write strobe |
| ram_wdata | output | 8 | Data toward the RAM data bus |
| ram_wdrive | output | 1 | Enable for the external tri-state data driver |
| ram_rdata | input | 8 | Data sampled from the RAM data bus |

## Verification
The assertions assume that the host changes its request fields only between accepted requests. They also assume that `ram_rdata` has settled once the access-time count has elapsed. The bench keeps within these assumptions by driving the host inputs at the falling edge and holding them until acceptance. Its RAM model returns a poison byte until output enable and the selects have been active for the access time. During busy periods the bench deliberately holds a conflicting write request, and it drops that request on the same falling edge at which `req_ready` returns. This makes the ignored-request case observable without breaking the handshake.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared types and constant helpers for the SRAM access controller.
// Assumes: used only at elaboration for widths and derived cycle counts.
package sram_ctrl_pkg;

    // Access phase of the controller.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_t;

    // Larger of two integers, used to derive effective cycle counts.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
// Module: cycle counter spanning one RAM access.
// Counts from zero while an access runs and flags the final cycle.
// Assumes: last_i stays constant for the duration of one access.
module sram_cyc_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] last_i,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_d_o,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_q;

    assign cnt_q_o = cnt_q;
    assign done_o  = run_i && (cnt_q == last_i);

    // Next count: restart on a new access, advance inside one, else rest at zero.
    always_comb begin
        if (start_i)
            cnt_d_o = '0;
        else if (run_i && !done_o)
            cnt_d_o = cnt_q + 1'b1;
        else
            cnt_d_o = '0;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d_o;
    end

    // R8
    cnt_within_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q <= last_i));

endmodule

// File: rtl/sram_pin_driver.sv
// Module: registered RAM pin generator.
// Decodes the next phase and count into select, enable, strobe and driver
// levels, and registers them so every RAM pin comes straight from a flop.
// Latches address and write data when a request is accepted.
// Assumes: load_i is high only on the acceptance edge.
module sram_pin_driver
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 3,
    parameter int WP_EFF    = 2,
    parameter int DRV_START = 0,
    parameter bit OE_IN_WR  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase_d_i,
    input  logic [CNT_W-1:0]  cnt_d_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic              ram_ce_n_o,
    output logic              ram_ce_hi_o,
    output logic              ram_oe_n_o,
    output logic              ram_we_n_o,
    output logic [DATA_W-1:0] ram_wdata_o,
    output logic              ram_wdrive_o
);

    logic rd_on, wr_on, drv_on, oe_on;

    // Decode of the levels the pins take in the next cycle.
    always_comb begin
        rd_on  = (phase_d_i == PH_READ);
        wr_on  = (phase_d_i == PH_WRITE) && (cnt_d_i < CNT_W'(WP_EFF));
        drv_on = wr_on && (cnt_d_i >= CNT_W'(DRV_START));
        oe_on  = rd_on || (OE_IN_WR && wr_on);
    end

    // Strobe registers; reset leaves the RAM deselected and the bus released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_ce_n_o   <= 1'b1;
            ram_ce_hi_o  <= 1'b0;
            ram_oe_n_o   <= 1'b1;
            ram_we_n_o   <= 1'b1;
            ram_wdrive_o <= 1'b0;
        end else begin
            ram_ce_n_o   <= !(rd_on || wr_on);
            ram_ce_hi_o  <= rd_on || wr_on;
            ram_oe_n_o   <= !oe_on;
            ram_we_n_o   <= !wr_on;
            ram_wdrive_o <= drv_on;
        end
    end

    // Address and write data held for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_addr_o  <= '0;
            ram_wdata_o <= '0;
        end else if (load_i) begin
            ram_addr_o  <= addr_i;
            ram_wdata_o <= wdata_i;
        end
    end

    // Checker: length of the current low run of the write strobe.
    logic [CNT_W:0] we_run;
    always_ff @(posedge clk) begin
        if (!rst_n)
            we_run <= '0;
        else if (!ram_we_n_o)
            we_run <= we_run + 1'b1;
        else
            we_run <= '0;
    end

    // R3
    we_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n_o) |-> (we_run == (CNT_W+1)'(WP_EFF)));

    // R5
    drv_after_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (OE_IN_WR && $fell(ram_we_n_o)) |-> (DRV_START == 0) == ram_wdrive_o);

endmodule

// File: rtl/sram_rd_capture.sv
// Module: read data capture register with a one-cycle valid flag.
// Assumes: capture_i is high for a single cycle per read access.
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] ram_rdata_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o
);

    // Sample the RAM bus and raise the flag for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= capture_i;
            if (capture_i)
                rd_data_o <= ram_rdata_i;
        end
    end

    // R7
    rd_valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |=> !rd_valid_o);

endmodule

// File: rtl/sram_ctrl.sv
// Module: asynchronous SRAM access controller, top level.
// Accepts one host request at a time and sequences the RAM selects, output
// enable, write strobe and data driver with cycle-count timing parameters.
// Assumes: host holds request fields stable until accepted; ram_rdata has
// settled once T_RD_ACCESS cycles of active read strobes have elapsed.
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W           = 13,
    parameter int DATA_W           = 8,
    parameter int T_RD_CYCLE       = 2,
    parameter int T_RD_ACCESS      = 2,
    parameter int T_WR_PULSE       = 2,
    parameter int T_WR_HIZ         = 1,
    parameter int T_DATA_SETUP     = 1,
    parameter int T_WR_CYCLE       = 2,
    parameter bit KEEP_OE_IN_WRITE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_ce_n,
    output logic              ram_ce_hi,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_wdrive,
    input  logic [DATA_W-1:0] ram_rdata
);

    // Effective cycle counts, each at least one cycle.
    localparam int RD_ACC    = imax(T_RD_ACCESS, 1);
    localparam int RD_TOT    = imax(imax(T_RD_CYCLE, 1), RD_ACC);
    localparam int DRV_START = KEEP_OE_IN_WRITE ? imax(T_WR_HIZ, 1) : 0;
    localparam int WP_EFF    = imax(imax(T_WR_PULSE, 1), DRV_START + imax(T_DATA_SETUP, 1));
    localparam int WR_TOT    = imax(imax(T_WR_CYCLE, 1), WP_EFF);
    localparam int CNT_W     = $clog2(imax(RD_TOT, WR_TOT) + 1);

    phase_t           phase_q, phase_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, last_idx;
    logic             accept, span_end, running, capture;

    assign req_ready = (phase_q == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign running   = (phase_q != PH_IDLE);
    assign last_idx  = (phase_q == PH_READ) ? CNT_W'(RD_TOT - 1) : CNT_W'(WR_TOT - 1);
    assign capture   = (phase_q == PH_READ) && (cnt_q == CNT_W'(RD_ACC - 1));

    sram_cyc_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (accept),
        .run_i   (running),
        .last_i  (last_idx),
        .cnt_q_o (cnt_q),
        .cnt_d_o (cnt_d),
        .done_o  (span_end)
    );

    // Phase sequencing: idle -> read or write -> idle at the end of the span.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:  if (accept) phase_d = req_we ? PH_WRITE : PH_READ;
            PH_READ,
            PH_WRITE: if (span_end) phase_d = PH_IDLE;
            default:  phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= PH_IDLE;
        else
            phase_q <= phase_d;
    end

    sram_pin_driver #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .WP_EFF    (WP_EFF),
        .DRV_START (DRV_START),
        .OE_IN_WR  (KEEP_OE_IN_WRITE)
    ) u_pins (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_d_i    (phase_d),
        .cnt_d_i      (cnt_d),
        .load_i       (accept),
        .addr_i       (req_addr),
        .wdata_i      (req_wdata),
        .ram_addr_o   (ram_addr),
        .ram_ce_n_o   (ram_ce_n),
        .ram_ce_hi_o  (ram_ce_hi),
        .ram_oe_n_o   (ram_oe_n),
        .ram_we_n_o   (ram_we_n),
        .ram_wdata_o  (ram_wdata),
        .ram_wdrive_o (ram_wdrive)
    );

    sram_rd_capture #(
        .DATA_W (DATA_W)
    ) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture_i   (capture),
        .ram_rdata_i (ram_rdata),
        .rd_data_o   (rd_data),
        .rd_valid_o  (rd_valid)
    );

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R3
    we_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (!ram_ce_n && ram_ce_hi));

    // R6
    drive_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wdrive |-> !ram_we_n);

    // R4
    oe_off_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!KEEP_OE_IN_WRITE && !ram_we_n) |-> ram_oe_n);

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_ce_n && $past(!ram_ce_n)) |-> $stable(ram_addr));

    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ram_ce_n && !ram_ce_hi && ram_we_n && ram_oe_n && !ram_wdrive));

endmodule

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps

// Bench RAM model and pin watcher: stores writes made during a valid strobe
// overlap, returns a poison byte until the read access time has elapsed,
// and counts every pin-level rule violation it sees at the falling edge.
module tb_sram_side #(
    parameter int ACC     = 2,
    parameter int EXP_WP  = 2,
    parameter int EXP_DRV = 2,
    parameter int HIZ     = 1,
    parameter bit OE_LOW  = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ready,
    input  logic [12:0] addr,
    input  logic        ce_n,
    input  logic        ce_hi,
    input  logic        oe_n,
    input  logic        we_n,
    input  logic [7:0]  wdata,
    input  logic        wdrive,
    output logic [7:0]  rdata,
    output int          pulses,
    output int          bad_width,
    output int          bad_drvlen,
    output int          bad_oe,
    output int          bad_drv,
    output int          bad_sel,
    output int          bad_pair,
    output int          bad_idle,
    output int          contend,
    output int          bad_addr
);
    logic [7:0]  mem [int];
    int          age, wlow, drv;
    logic        prev_sel;
    logic [12:0] prev_addr;
    logic        sel;

    initial begin
        rdata = 8'hEE; pulses = 0; bad_width = 0; bad_drvlen = 0; bad_oe = 0;
        bad_drv = 0; bad_sel = 0; bad_pair = 0; bad_idle = 0; contend = 0;
        bad_addr = 0; age = 0; wlow = 0; drv = 0; prev_sel = 0; prev_addr = '0;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            sel = !ce_n && ce_hi;
            if ((!ce_n) != ce_hi) bad_pair++;
            if (ready && !(ce_n && !ce_hi && we_n && oe_n && !wdrive)) bad_idle++;
            if (!we_n && !sel) bad_sel++;
            if (wdrive && (we_n || !sel)) bad_drv++;
            if (sel && prev_sel && addr != prev_addr) bad_addr++;
            if (!we_n) begin
                wlow++;
                if (OE_LOW ? oe_n : !oe_n) bad_oe++;
                if (wdrive) drv++;
                if (!oe_n && wdrive && wlow <= HIZ) contend++;
            end else if (wlow != 0) begin
                pulses++;
                if (wlow != EXP_WP) bad_width++;
                if (drv != EXP_DRV) bad_drvlen++;
                wlow = 0;
                drv = 0;
            end
            if (sel && !we_n && wdrive) mem[int'(addr)] = wdata;
            if (sel && !oe_n && we_n) age++; else age = 0;
            if (age >= ACC) rdata = mem.exists(int'(addr)) ? mem[int'(addr)] : 8'h00;
            else rdata = 8'hEE;
            prev_sel = sel;
            prev_addr = addr;
        end
    end
endmodule

// Scoreboard bench: host_op pushes expected read bytes, a monitor pops and
// compares on rd_valid; two controllers run the same traffic, one keeping
// output enable off in writes and one keeping it on with a stretched pulse.
module tb_sram_ctrl;
    localparam int RD_CYC = 3, RD_ACC = 2, WR_PULSE = 2, WR_HIZ = 1, DSETUP = 2, WR_CYC = 4;
    localparam int RD_TOT = 3, WR_TOT = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_we = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;

    logic        ready_a, rvalid_a, ce_n_a, ce_hi_a, oe_n_a, we_n_a, drv_a;
    logic [7:0]  rdata_a, wdata_a, ram_rd_a;
    logic [12:0] addr_a;
    logic        ready_b, rvalid_b, ce_n_b, ce_hi_b, oe_n_b, we_n_b, drv_b;
    logic [7:0]  rdata_b, wdata_b, ram_rd_b;
    logic [12:0] addr_b;

    int checks = 0, fails = 0, n_writes = 0;
    bit finished = 0;
    logic [7:0] shadow [int];
    logic [7:0] exp_q [$];

    int pa, wa, da, oa, ra, sa, ca, ia, ta, aa;
    int pb, wb, db, ob, rb, sb, cb, ib, tb_, ab;

    always #4 clk = ~clk;

    sram_ctrl #(
        .T_RD_CYCLE(RD_CYC), .T_RD_ACCESS(RD_ACC), .T_WR_PULSE(WR_PULSE),
        .T_WR_HIZ(WR_HIZ), .T_DATA_SETUP(DSETUP), .T_WR_CYCLE(WR_CYC),
        .KEEP_OE_IN_WRITE(1'b0)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(ready_a),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rdata_a), .rd_valid(rvalid_a), .ram_addr(addr_a),
        .ram_ce_n(ce_n_a), .ram_ce_hi(ce_hi_a), .ram_oe_n(oe_n_a), .ram_we_n(we_n_a),
        .ram_wdata(wdata_a), .ram_wdrive(drv_a), .ram_rdata(ram_rd_a)
    );

    sram_ctrl #(
        .T_RD_CYCLE(RD_CYC), .T_RD_ACCESS(RD_ACC), .T_WR_PULSE(WR_PULSE),
        .T_WR_HIZ(WR_HIZ), .T_DATA_SETUP(DSETUP), .T_WR_CYCLE(WR_CYC),
        .KEEP_OE_IN_WRITE(1'b1)
    ) dut_st (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(ready_b),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rdata_b), .rd_valid(rvalid_b), .ram_addr(addr_b),
        .ram_ce_n(ce_n_b), .ram_ce_hi(ce_hi_b), .ram_oe_n(oe_n_b), .ram_we_n(we_n_b),
        .ram_wdata(wdata_b), .ram_wdrive(drv_b), .ram_rdata(ram_rd_b)
    );

    // OE off in writes: pulse 2, driven from its first cycle (2 cycles).
    tb_sram_side #(.ACC(RD_ACC), .EXP_WP(2), .EXP_DRV(2), .HIZ(WR_HIZ), .OE_LOW(1'b0)) side_a (
        .clk(clk), .rst_n(rst_n), .ready(ready_a), .addr(addr_a), .ce_n(ce_n_a),
        .ce_hi(ce_hi_a), .oe_n(oe_n_a), .we_n(we_n_a), .wdata(wdata_a), .wdrive(drv_a),
        .rdata(ram_rd_a), .pulses(pa), .bad_width(wa), .bad_drvlen(da), .bad_oe(oa),
        .bad_drv(ra), .bad_sel(sa), .bad_pair(ca), .bad_idle(ia), .contend(ta), .bad_addr(aa)
    );

    // OE kept on: pulse max(2, 1+2)=3, driven from its second cycle (2 cycles).
    tb_sram_side #(.ACC(RD_ACC), .EXP_WP(3), .EXP_DRV(2), .HIZ(WR_HIZ), .OE_LOW(1'b1)) side_b (
        .clk(clk), .rst_n(rst_n), .ready(ready_b), .addr(addr_b), .ce_n(ce_n_b),
        .ce_hi(ce_hi_b), .oe_n(oe_n_b), .we_n(we_n_b), .wdata(wdata_b), .wdrive(drv_b),
        .rdata(ram_rd_b), .pulses(pb), .bad_width(wb), .bad_drvlen(db), .bad_oe(ob),
        .bad_drv(rb), .bad_sel(sb), .bad_pair(cb), .bad_idle(ib), .contend(tb_), .bad_addr(ab)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: one host request; optionally holds a conflicting write while busy.
    task automatic host_op(input bit we, input logic [12:0] a, input logic [7:0] d, input bit noise);
        int n;
        bit lat_ok;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        if (we) begin
            shadow[int'(a)] = d;
            n_writes++;
        end else begin
            exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00);
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = noise;
        if (noise) begin
            req_we = 1'b1; req_addr = a ^ 13'h0F0; req_wdata = 8'h77;
        end
        n = 0;
        lat_ok = 1'b1;
        while (!ready_a && n < 50) begin
            n++;
            if (rvalid_a != (!we && n == RD_ACC + 1)) lat_ok = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        if (rvalid_a) lat_ok = 1'b0;
        // R8: busy span length
        chk(n == (we ? WR_TOT : RD_TOT), "R8", "ready low cycles", n, we ? WR_TOT : RD_TOT);
        // R7: capture latency and single valid cycle
        if (!we) chk(lat_ok, "R7", "rd_valid timing", int'(lat_ok), 1);
    endtask

    // Monitor: pops expected read data as results appear.
    always @(negedge clk) begin
        if (rst_n && (rvalid_a || rvalid_b)) begin
            logic [7:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hEE;
            // R9: read returns the last written byte
            chk(rdata_a == e, "R9", "read data", rdata_a, e);
            // R5: stretched-write variant returns the same byte on the same cycle
            chk(rvalid_b && rdata_b == e, "R5", "read data (OE kept on)", rdata_b, e);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(ce_n_a && !ce_hi_a && oe_n_a && we_n_a && !drv_a, "R1", "reset pins",
            {ce_n_a, ce_hi_a, oe_n_a, we_n_a, drv_a}, 5'b10110);
        chk(ce_n_b && !ce_hi_b && oe_n_b && we_n_b && !drv_b, "R1", "reset pins (OE kept on)",
            {ce_n_b, ce_hi_b, oe_n_b, we_n_b, drv_b}, 5'b10110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready_a && ready_b, "R8", "ready after reset", {ready_a, ready_b}, 2'b11);

        host_op(1'b1, 13'h0000, 8'h11, 1'b0);
        host_op(1'b1, 13'h1FFF, 8'h5A, 1'b0);
        host_op(1'b1, 13'h0ABC, 8'hC3, 1'b0);
        host_op(1'b0, 13'h0000, 8'h00, 1'b0);
        host_op(1'b0, 13'h1FFF, 8'h00, 1'b0);
        host_op(1'b0, 13'h0ABC, 8'h00, 1'b0);
        host_op(1'b0, 13'h0123, 8'h00, 1'b0);
        // R8: write request held during busy periods must be ignored
        host_op(1'b0, 13'h0ABC, 8'h00, 1'b1);
        host_op(1'b1, 13'h0F0F, 8'h3C, 1'b1);
        host_op(1'b0, 13'h0ABC ^ 13'h0F0, 8'h00, 1'b0);
        host_op(1'b0, 13'h0F0F ^ 13'h0F0, 8'h00, 1'b0);
        host_op(1'b1, 13'h0ABC, 8'h96, 1'b0);
        host_op(1'b0, 13'h0ABC, 8'h00, 1'b0);
        for (int i = 0; i < 16; i++) begin
            logic [7:0] d;
            d = 8'(i * 29 + 3);
            if (d == 8'hEE) d = 8'hEF;
            host_op(1'b1, 13'(i * 373), d, 1'b0);
        end
        for (int i = 15; i >= 0; i--) host_op(1'b0, 13'(i * 373), 8'h00, 1'b0);
        repeat (3) @(negedge clk);

        chk(exp_q.size() == 0, "R7", "reads without result", exp_q.size(), 0);
        chk(pa == n_writes, "R8", "write pulses", pa, n_writes);
        chk(pb == n_writes, "R8", "write pulses (OE kept on)", pb, n_writes);
        chk(wa == 0, "R3", "pulse width errors", wa, 0);
        chk(wb == 0, "R3", "stretched pulse width errors", wb, 0);
        chk(oa == 0, "R4", "OE active in write", oa, 0);
        chk(ob == 0, "R5", "OE inactive in stretched write", ob, 0);
        chk(tb_ == 0, "R5", "bus contention cycles", tb_, 0);
        chk(da + db == 0, "R6", "driver span errors", da + db, 0);
        chk(ra + rb == 0, "R6", "driver outside pulse", ra + rb, 0);
        chk(sa + sb == 0, "R3", "strobe outside select", sa + sb, 0);
        chk(ca + cb == 0, "R2", "half-selected cycles", ca + cb, 0);
        chk(ia + ib == 0, "R1", "idle pin errors", ia + ib, 0);
        chk(aa + ab == 0, "R9", "address change while selected", aa + ab, 0);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule